// File: doc/BRIEF.md
# MI Coherence L1 Cache Controller

This block is a private first-level cache controller that keeps its lines coherent with a directory using only two stable states, Modified and Invalid, plus transient states for misses and evictions in flight. Since a line is either owned or absent, every processor access, reads included, obtains exclusive ownership. The processor side offers loads, instruction fetches and stores through a valid/ready port. Completions come back as a one-cycle pulse carrying the line's word.

Toward the directory the controller issues ownership requests (GETX) and write-backs carrying data (PUTX). It accepts DATA responses on one input channel. It accepts forwarded GETX, INV, WB_ACK and WB_NACK messages on a second input channel. A forwarded GETX is answered with a DATA message to the named requestor. The array is direct-mapped, one data word per line, and a single write-back buffer holds an evicted dirty line until the directory acknowledges it. Only one miss is outstanding at a time. At most one event is taken per cycle: the response channel has priority, then the forward channel, then the processor.

Top module: `mi_l1_ctrl`

## Requirements
- R1: After reset every line is Invalid, the write-back buffer is empty, and `cpu_done`, `dreq_valid`, `out_valid` and `proto_err` are low.
- R2: A load (`cpu_op`=0), fetch (1) or store (2 or 3) to an address whose line slot is free is accepted. In the next cycle the controller sends `dreq_type`=0 (GETX) for that address.
- R3: A DATA response (`rsp_type`=0) matching the outstanding miss completes it in the next cycle. A load returns the response word. A store writes its own word and returns it. The line ends Modified.
- R4: An access to a Modified line is accepted at once and completes in the next cycle with no directory request. A store updates the word that later loads return.
- R5: A forwarded GETX (`fwd_type`=0) to a Modified line produces, in the next cycle, `out_valid` with the line's word and `out_dest` equal to `fwd_src`. The line becomes Invalid, so a later access misses again.
- R6: A miss whose slot holds a Modified line of another address is not accepted in that cycle. Instead it sends `dreq_type`=1 (PUTX) with the victim's address and word, then retries and sends GETX for the new address.
- R7: INV (`fwd_type`=1) to a Modified line sends a PUTX with its word and enters MI. In MI a further INV is consumed with no output and no error. WB_ACK (`fwd_type`=2) then frees the buffer.
- R8: A forwarded GETX in MI answers with the buffered word and enters II. WB_NACK (`fwd_type`=3) in II frees the buffer.
- R9: WB_NACK in MI enters MII. A forwarded GETX in MII answers with the buffered word and frees the buffer.
- R10: Processor requests are held (not ready) while a miss is outstanding or while the write-back buffer holds their address. A forwarded GETX or INV to a line in IS or IM is held until its data arrives.
- R11: When several channels are valid, only the response channel is served, then the forward channel, then the processor. At most one handshake occurs per cycle.
- R12: A message type not defined for its channel or for the line's state (`fwd_type` 4 to 7, a non-zero `rsp_type`, DATA with no matching miss) is consumed and sets `proto_err`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_ready | output | 1 | Processor request accepted this cycle |
| cpu_op | input | 2 | 0 load, 1 fetch, 2 or 3 store |
| cpu_addr | input | AW | Line address of the request |
| cpu_wdata | input | DW | Store word |
| cpu_done | output | 1 | Completion pulse |
| cpu_rdata | output | DW | Line word at completion |
| dreq_valid | output | 1 | Directory request pulse |
| dreq_type | output | 1 | 0 GETX, 1 PUTX |
| dreq_addr | output | AW | Directory request address |
| dreq_data | output | DW | Write-back word for PUTX |
| rsp_valid | input | 1 | Response valid |
| rsp_ready | output | 1 | Response consumed |
| rsp_type | input | 2 | 0 DATA, others illegal |
| rsp_addr | input | AW | Response address |
| rsp_data | input | DW | Response word |
| fwd_valid | input | 1 | Forwarded message valid |
| fwd_ready | output | 1 | Forwarded message consumed |
| fwd_type | input | 3 | 0 GETX, 1 INV, 2 WB_ACK, 3 WB_NACK, others illegal |
| fwd_addr | input | AW | Forwarded message address |
| fwd_src | input | RW | Requestor to answer |
| out_valid | output | 1 | DATA to requestor pulse |
| out_addr | output | AW | Address of that DATA |
| out_data | output | DW | Word of that DATA |
| out_dest | output | RW | Requestor the DATA goes to |
| proto_err | output | 1 | Sticky protocol error flag |

## Verification
The bench aims at the write-back races. A GETX arriving in MI, a NACK followed by a GETX, and a NACK arriving after the buffer has already answered a GETX all exercise them. A design that mixes these up would answer with stale array data, keep a buffer locked forever, or flag a legal message as an error. It holds a forwarded INV against a pending fill and presents all three channels at once, so a design with the wrong priority or a missing stall would take two handshakes in one cycle or invalidate a line that has not been filled yet. A long random run of loads and stores over a few addresses that alias in the array checks every returned word against a reference copy of memory. Any fault in victim write-back or refill would show up as a wrong word.

// File: rtl/mi_l1_ctrl.sv
module mi_l1_ctrl #(
  parameter int AW = 8,
  parameter int IW = 2,
  parameter int DW = 32,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_valid,
  output logic          cpu_ready,
  input  logic [1:0]    cpu_op,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_done,
  output logic [DW-1:0] cpu_rdata,
  output logic          dreq_valid,
  output logic          dreq_type,
  output logic [AW-1:0] dreq_addr,
  output logic [DW-1:0] dreq_data,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [1:0]    rsp_type,
  input  logic [AW-1:0] rsp_addr,
  input  logic [DW-1:0] rsp_data,
  input  logic          fwd_valid,
  output logic          fwd_ready,
  input  logic [2:0]    fwd_type,
  input  logic [AW-1:0] fwd_addr,
  input  logic [RW-1:0] fwd_src,
  output logic          out_valid,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data,
  output logic [RW-1:0] out_dest,
  output logic          proto_err
);
  localparam int LINES = 1 << IW;
  localparam int TW    = AW - IW;
  localparam logic [2:0] F_GETX = 3'd0, F_INV = 3'd1, F_ACK = 3'd2, F_NACK = 3'd3;

  typedef enum logic [2:0] {S_I, S_M, S_IS, S_IM, S_MI, S_II, S_MII} st_t;

  st_t           st_q  [LINES];
  logic [TW-1:0] tag_q [LINES];
  logic [DW-1:0] dat_q [LINES];

  logic          wb_v;
  st_t           wb_st;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;

  logic          miss_v, miss_st;
  logic [AW-1:0] miss_addr;
  logic [DW-1:0] miss_wd;

  function automatic st_t look(input logic [AW-1:0] a);
    if (wb_v && wb_addr == a) return wb_st;
    if (st_q[a[IW-1:0]] != S_I && tag_q[a[IW-1:0]] == a[AW-1:IW]) return st_q[a[IW-1:0]];
    return S_I;
  endfunction

  logic [IW-1:0] cidx, fidx, midx, ev_idx;
  st_t           cst, fst;
  logic          c_occ, c_go, c_evict, f_stall, c_turn, f_inv_m, do_ev;

  assign cidx = cpu_addr[IW-1:0];
  assign fidx = fwd_addr[IW-1:0];
  assign midx = miss_addr[IW-1:0];
  assign cst  = look(cpu_addr);
  assign fst  = look(fwd_addr);

  assign c_occ   = st_q[cidx] == S_M && tag_q[cidx] != cpu_addr[AW-1:IW];
  assign c_go    = !miss_v && (cst == S_M || (cst == S_I && st_q[cidx] == S_I));
  assign c_evict = !miss_v && cst == S_I && c_occ && !wb_v;
  assign f_stall = ((fwd_type == F_GETX || fwd_type == F_INV) && (fst == S_IS || fst == S_IM))
                 || (fwd_type == F_INV && fst == S_M && wb_v);

  assign c_turn    = !rsp_valid && !fwd_valid && cpu_valid;
  assign rsp_ready = rsp_valid;
  assign fwd_ready = !rsp_valid && fwd_valid && !f_stall;
  assign cpu_ready = c_turn && c_go;

  assign f_inv_m = fwd_ready && fwd_type == F_INV && fst == S_M;
  assign do_ev   = f_inv_m || (c_turn && c_evict);
  assign ev_idx  = f_inv_m ? fidx : cidx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= S_I;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
      wb_v <= 1'b0; wb_st <= S_I; wb_addr <= '0; wb_data <= '0;
      miss_v <= 1'b0; miss_st <= 1'b0; miss_addr <= '0; miss_wd <= '0;
      cpu_done <= 1'b0; cpu_rdata <= '0;
      dreq_valid <= 1'b0; dreq_type <= 1'b0; dreq_addr <= '0; dreq_data <= '0;
      out_valid <= 1'b0; out_addr <= '0; out_data <= '0; out_dest <= '0;
      proto_err <= 1'b0;
    end else begin
      cpu_done   <= 1'b0;
      dreq_valid <= 1'b0;
      out_valid  <= 1'b0;

      if (do_ev) begin
        wb_v        <= 1'b1;
        wb_st       <= S_MI;
        wb_addr     <= {tag_q[ev_idx], ev_idx};
        wb_data     <= dat_q[ev_idx];
        st_q[ev_idx] <= S_I;
        dreq_valid  <= 1'b1;
        dreq_type   <= 1'b1;
        dreq_addr   <= {tag_q[ev_idx], ev_idx};
        dreq_data   <= dat_q[ev_idx];
      end

      if (rsp_valid) begin
        if (rsp_type == 2'd0 && miss_v && rsp_addr == miss_addr) begin
          dat_q[midx] <= miss_st ? miss_wd : rsp_data;
          cpu_rdata   <= miss_st ? miss_wd : rsp_data;
          st_q[midx]  <= S_M;
          miss_v      <= 1'b0;
          cpu_done    <= 1'b1;
        end else begin
          proto_err <= 1'b1;
        end
      end else if (fwd_ready) begin
        case (fwd_type)
          F_GETX: begin
            if (fst == S_M) begin
              out_valid  <= 1'b1;
              out_addr   <= fwd_addr;
              out_data   <= dat_q[fidx];
              out_dest   <= fwd_src;
              st_q[fidx] <= S_I;
            end else if (fst == S_MI || fst == S_MII) begin
              out_valid <= 1'b1;
              out_addr  <= fwd_addr;
              out_data  <= wb_data;
              out_dest  <= fwd_src;
              if (fst == S_MI) wb_st <= S_II;
              else             wb_v  <= 1'b0;
            end else begin
              proto_err <= 1'b1;
            end
          end
          F_INV:  if (fst != S_M && fst != S_MI) proto_err <= 1'b1;
          F_ACK: begin
            if (fst == S_MI) wb_v <= 1'b0;
            else             proto_err <= 1'b1;
          end
          F_NACK: begin
            if (fst == S_MI)      wb_st <= S_MII;
            else if (fst == S_II) wb_v  <= 1'b0;
            else                  proto_err <= 1'b1;
          end
          default: proto_err <= 1'b1;
        endcase
      end else if (cpu_ready) begin
        if (cst == S_M) begin
          cpu_done <= 1'b1;
          if (cpu_op[1]) begin
            dat_q[cidx] <= cpu_wdata;
            cpu_rdata   <= cpu_wdata;
          end else begin
            cpu_rdata <= dat_q[cidx];
          end
        end else begin
          tag_q[cidx] <= cpu_addr[AW-1:IW];
          st_q[cidx]  <= cpu_op[1] ? S_IM : S_IS;
          miss_v      <= 1'b1;
          miss_st     <= cpu_op[1];
          miss_addr   <= cpu_addr;
          miss_wd     <= cpu_wdata;
          dreq_valid  <= 1'b1;
          dreq_type   <= 1'b0;
          dreq_addr   <= cpu_addr;
          dreq_data   <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/mi_l1_ctrl_chk.sv
module mi_l1_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_valid,
  input logic       cpu_ready,
  input logic       cpu_done,
  input logic       dreq_valid,
  input logic       dreq_type,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [1:0] rsp_type,
  input logic       fwd_valid,
  input logic       fwd_ready,
  input logic [2:0] fwd_type,
  input logic       out_valid,
  input logic       proto_err
);
  a_r11_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_valid && rsp_ready, fwd_valid && fwd_ready, cpu_valid && cpu_ready}));

  a_r11_rsp_first: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_ready || cpu_ready) |-> !rsp_valid);

  a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  a_r5_data_source: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(fwd_valid && fwd_ready && fwd_type == 3'd0));

  a_r4_done_source: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> $past((rsp_valid && rsp_ready && rsp_type == 2'd0) || (cpu_valid && cpu_ready)));

  a_r2_getx_source: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq_valid && !dreq_type) |-> $past(cpu_valid && cpu_ready));

  a_r6_putx_source: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq_valid && dreq_type) |-> $past((cpu_valid && !cpu_ready) || (fwd_valid && fwd_ready && fwd_type == 3'd1)));
endmodule

bind mi_l1_ctrl mi_l1_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
  .cpu_done(cpu_done), .dreq_valid(dreq_valid), .dreq_type(dreq_type),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_type(rsp_type),
  .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_type(fwd_type),
  .out_valid(out_valid), .proto_err(proto_err)
);

// File: tb/sim_mi_l1_ctrl.sv
`timescale 1ns/1ps
module sim_mi_l1_ctrl;
  localparam int AW = 8, IW = 2, DW = 32, RW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_valid = 0, cpu_ready; logic [1:0] cpu_op = 0;
  logic [AW-1:0] cpu_addr = 0; logic [DW-1:0] cpu_wdata = 0;
  logic cpu_done; logic [DW-1:0] cpu_rdata;
  logic dreq_valid, dreq_type; logic [AW-1:0] dreq_addr; logic [DW-1:0] dreq_data;
  logic rsp_valid = 0, rsp_ready; logic [1:0] rsp_type = 0;
  logic [AW-1:0] rsp_addr = 0; logic [DW-1:0] rsp_data = 0;
  logic fwd_valid = 0, fwd_ready; logic [2:0] fwd_type = 0;
  logic [AW-1:0] fwd_addr = 0; logic [RW-1:0] fwd_src = 0;
  logic out_valid; logic [AW-1:0] out_addr; logic [DW-1:0] out_data; logic [RW-1:0] out_dest;
  logic proto_err;

  always #2.5 clk = ~clk;

  mi_l1_ctrl #(.AW(AW), .IW(IW), .DW(DW), .RW(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_op(cpu_op),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .dreq_valid(dreq_valid), .dreq_type(dreq_type), .dreq_addr(dreq_addr), .dreq_data(dreq_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_type(rsp_type), .rsp_addr(rsp_addr),
    .rsp_data(rsp_data), .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_type(fwd_type),
    .fwd_addr(fwd_addr), .fwd_src(fwd_src), .out_valid(out_valid), .out_addr(out_addr),
    .out_data(out_data), .out_dest(out_dest), .proto_err(proto_err));

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] dmem [256];
  logic [DW-1:0] refm [256];

  bit auto_dir = 0;
  bit pend_data = 0, pend_ack = 0;
  logic [AW-1:0] pend_da = 0, pend_aa = 0;
  bit r_acc, f_acc, c_acc, seen_done, seen_out;
  logic [DW-1:0] done_d, out_d, putx_d;
  logic [AW-1:0] out_a, getx_a, putx_a;
  logic [RW-1:0] out_dst;
  int n_getx = 0, n_putx = 0;

  function automatic logic [DW-1:0] init_val(input int a);
    return {a[7:0], ~a[7:0], a[7:0] ^ 8'h5a, 8'h3c};
  endfunction

  function automatic logic [DW-1:0] exp_load(input logic [AW-1:0] a);
    return refm[a];
  endfunction

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic run_cycle();
    if (auto_dir) begin
      rsp_valid = pend_data; rsp_type = 2'd0; rsp_addr = pend_da; rsp_data = dmem[pend_da];
      fwd_valid = pend_ack;  fwd_type = 3'd2; fwd_addr = pend_aa;
    end
    #1;
    r_acc = rsp_valid && rsp_ready;
    f_acc = fwd_valid && fwd_ready;
    c_acc = cpu_valid && cpu_ready;
    @(posedge clk); #1;
    if (auto_dir) begin
      if (r_acc) pend_data = 0;
      if (f_acc) pend_ack = 0;
    end
    seen_done = cpu_done; done_d = cpu_rdata;
    seen_out = out_valid; out_a = out_addr; out_d = out_data; out_dst = out_dest;
    if (dreq_valid) begin
      if (!dreq_type) begin
        n_getx++; getx_a = dreq_addr;
        if (auto_dir) begin pend_data = 1; pend_da = dreq_addr; end
      end else begin
        n_putx++; putx_a = dreq_addr; putx_d = dreq_data;
        dmem[dreq_addr] = dreq_data;
        if (auto_dir) begin pend_ack = 1; pend_aa = dreq_addr; end
      end
    end
  endtask

  task automatic set_auto(input bit on);
    auto_dir = on; rsp_valid = 0; fwd_valid = 0; pend_data = 0; pend_ack = 0;
  endtask

  task automatic do_access(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                           output logic [DW-1:0] rd, output int cyc);
    n_getx = 0; n_putx = 0; rd = '0; cyc = 0; seen_done = 0;
    cpu_valid = 1; cpu_op = op; cpu_addr = a; cpu_wdata = wd;
    for (int k = 0; k < 60; k++) begin
      run_cycle(); cyc++;
      if (c_acc) cpu_valid = 0;
      if (seen_done) begin rd = done_d; break; end
    end
    cpu_valid = 0;
    if (!seen_done) chk("R10 access completes", 0, 1);
  endtask

  task automatic send_fwd(input logic [2:0] t, input logic [AW-1:0] a, input logic [RW-1:0] s);
    n_getx = 0; n_putx = 0;
    fwd_valid = 1; fwd_type = t; fwd_addr = a; fwd_src = s;
    run_cycle();
    fwd_valid = 0;
  endtask

  task automatic try_cpu_stall(input logic [AW-1:0] a, input string what);
    cpu_valid = 1; cpu_op = 2'd0; cpu_addr = a;
    run_cycle();
    chk(what, c_acc, 0);
    cpu_valid = 0;
  endtask

  bit finished = 0;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog: actual hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    int cyc;
    int seed;
    for (int a = 0; a < 256; a++) begin dmem[a] = init_val(a); refm[a] = init_val(a); end
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset cpu_done", cpu_done, 0);
    chk("R1 reset dreq_valid", dreq_valid, 0);
    chk("R1 reset out_valid", out_valid, 0);
    chk("R1 reset proto_err", proto_err, 0);
    rst_n = 1;
    @(posedge clk); #1;
    chk("R1 idle after reset", {cpu_done, dreq_valid, out_valid, proto_err}, 0);

    set_auto(1);
    // R2 R3 load miss
    do_access(2'd0, 8'h10, 0, rd, cyc);
    chk("R2 one GETX", n_getx, 1);
    chk("R2 GETX address", getx_a, 8'h10);
    chk("R3 load miss data", rd, exp_load(8'h10));
    chk("R3 miss latency", cyc, 2);
    // R4 hit
    do_access(2'd1, 8'h10, 0, rd, cyc);
    chk("R4 hit no request", n_getx + n_putx, 0);
    chk("R4 hit latency", cyc, 1);
    chk("R4 hit data", rd, exp_load(8'h10));
    // R3 store miss
    do_access(2'd2, 8'h21, 32'haaaa5555, rd, cyc);
    refm[8'h21] = 32'haaaa5555;
    chk("R3 store miss GETX", n_getx, 1);
    chk("R3 store returns word", rd, 32'haaaa5555);
    do_access(2'd0, 8'h21, 0, rd, cyc);
    chk("R4 load after store", rd, 32'haaaa5555);
    // R6 replacement
    do_access(2'd0, 8'h14, 0, rd, cyc);
    chk("R6 victim PUTX", n_putx, 1);
    chk("R6 PUTX address", putx_a, 8'h10);
    chk("R6 retry GETX", getx_a, 8'h14);
    chk("R6 new line data", rd, exp_load(8'h14));
    do_access(2'd3, 8'h25, 32'h0bad_f00d, rd, cyc);
    refm[8'h25] = 32'h0bad_f00d;
    chk("R6 dirty PUTX data", putx_d, 32'haaaa5555);
    chk("R6 store retried", rd, 32'h0bad_f00d);

    // R5 forwarded GETX in M
    set_auto(0);
    send_fwd(3'd0, 8'h14, 3'd5);
    chk("R5 GETX consumed", f_acc, 1);
    chk("R5 DATA sent", seen_out, 1);
    chk("R5 DATA word", out_d, exp_load(8'h14));
    chk("R5 DATA dest", out_dst, 3'd5);
    chk("R5 DATA addr", out_a, 8'h14);
    dmem[8'h14] = out_d;
    set_auto(1);
    do_access(2'd0, 8'h14, 0, rd, cyc);
    chk("R5 line invalid after GETX", n_getx, 1);

    // R7 INV, INV in MI, WB_ACK
    set_auto(0);
    send_fwd(3'd1, 8'h25, 0);
    chk("R7 INV PUTX", n_putx, 1);
    chk("R7 INV PUTX data", putx_d, 32'h0bad_f00d);
    send_fwd(3'd1, 8'h25, 0);
    chk("R7 INV in MI consumed", f_acc, 1);
    chk("R7 INV in MI silent", {seen_out, n_putx[0]}, 0);
    chk("R7 INV in MI no error", proto_err, 0);
    try_cpu_stall(8'h25, "R10 request stalls in MI");
    send_fwd(3'd2, 8'h25, 0);
    chk("R7 WB_ACK consumed", f_acc, 1);
    chk("R7 WB_ACK no error", proto_err, 0);
    set_auto(1);
    do_access(2'd0, 8'h25, 0, rd, cyc);
    chk("R7 buffer freed by ack", n_getx, 1);
    chk("R7 refetched data", rd, 32'h0bad_f00d);

    // R8 GETX in MI then NACK in II
    set_auto(0);
    send_fwd(3'd1, 8'h25, 0);
    send_fwd(3'd0, 8'h25, 3'd3);
    chk("R8 buffer DATA sent", seen_out, 1);
    chk("R8 buffer DATA word", out_d, 32'h0bad_f00d);
    chk("R8 buffer DATA dest", out_dst, 3'd3);
    dmem[8'h25] = out_d;
    try_cpu_stall(8'h25, "R10 request stalls in II");
    send_fwd(3'd3, 8'h25, 0);
    chk("R8 NACK in II consumed", f_acc, 1);
    chk("R8 NACK in II no error", proto_err, 0);
    set_auto(1);
    do_access(2'd0, 8'h25, 0, rd, cyc);
    chk("R8 buffer freed by NACK", n_getx, 1);

    // R9 NACK in MI then GETX in MII
    set_auto(0);
    send_fwd(3'd1, 8'h25, 0);
    send_fwd(3'd3, 8'h25, 0);
    chk("R9 NACK in MI consumed", f_acc, 1);
    chk("R9 NACK silent", {seen_out, proto_err}, 0);
    try_cpu_stall(8'h25, "R10 request stalls in MII");
    send_fwd(3'd0, 8'h25, 3'd6);
    chk("R9 MII DATA sent", seen_out, 1);
    chk("R9 MII DATA word", out_d, 32'h0bad_f00d);
    chk("R9 MII DATA dest", out_dst, 3'd6);
    dmem[8'h25] = out_d;
    set_auto(1);
    do_access(2'd0, 8'h25, 0, rd, cyc);
    chk("R9 buffer freed", n_getx, 1);

    // R10 R11 stalls during fill, priority
    set_auto(0);
    n_getx = 0;
    cpu_valid = 1; cpu_op = 2'd0; cpu_addr = 8'h33;
    run_cycle();
    cpu_valid = 0;
    chk("R2 miss accepted", c_acc, 1);
    chk("R2 GETX for miss", getx_a, 8'h33);
    send_fwd(3'd1, 8'h33, 0);
    chk("R10 INV held during fill", f_acc, 0);
    try_cpu_stall(8'h12, "R10 second miss held");
    rsp_valid = 1; rsp_type = 0; rsp_addr = 8'h33; rsp_data = 32'h1234_5678;
    fwd_valid = 1; fwd_type = 3'd0; fwd_addr = 8'h33; fwd_src = 3'd2;
    cpu_valid = 1; cpu_op = 2'd0; cpu_addr = 8'h12;
    run_cycle();
    chk("R11 response served first", {r_acc, f_acc, c_acc}, 3'b100);
    chk("R3 fill completes", seen_done, 1);
    chk("R3 fill data", done_d, 32'h1234_5678);
    rsp_valid = 0;
    run_cycle();
    chk("R11 forward before cpu", {f_acc, c_acc}, 2'b10);
    chk("R5 DATA after fill", out_d, 32'h1234_5678);
    chk("R5 DATA dest after fill", out_dst, 3'd2);
    fwd_valid = 0;
    dmem[8'h33] = 32'h1234_5678; refm[8'h33] = 32'h1234_5678;
    run_cycle();
    chk("R11 cpu served when alone", c_acc, 1);
    cpu_valid = 0;
    rsp_valid = 1; rsp_addr = 8'h12; rsp_data = dmem[8'h12];
    run_cycle();
    rsp_valid = 0;
    chk("R3 second fill data", done_d, exp_load(8'h12));

    // random loads and stores over aliasing addresses
    set_auto(1);
    seed = 20240611;
    void'($urandom(seed));
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      logic [1:0] op;
      logic [DW-1:0] wd;
      a  = AW'($urandom_range(0, 31));
      op = 2'($urandom_range(0, 3));
      wd = $urandom;
      do_access(op, a, wd, rd, cyc);
      if (!op[1]) chk("R3 R4 R6 random load", rd, exp_load(a));
      else begin
        chk("R4 R6 random store", rd, wd);
        refm[a] = wd;
      end
    end
    chk("R12 no error on legal traffic", proto_err, 0);

    // R12 illegal types
    set_auto(0);
    send_fwd(3'd5, 8'h40, 0);
    chk("R12 illegal forward consumed", f_acc, 1);
    chk("R12 error raised", proto_err, 1);
    run_cycle();
    chk("R12 error sticky", proto_err, 1);
    rsp_valid = 1; rsp_type = 2'd1; rsp_addr = 8'h40;
    run_cycle();
    rsp_valid = 0;
    chk("R12 illegal response consumed", r_acc, 1);
    chk("R12 nothing completed", seen_done, 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule